// File: doc/BRIEF.md
# Real-Time Seconds Counter with Compare Alarm

This block keeps a 32-bit count of elapsed seconds and raises an interrupt when that count reaches a programmed alarm value. The count advances by one on each single-cycle pulse of a 1 Hz tick input, which is made outside the block. Software reaches the block through a simple word-addressed register port. It can run or stop the timer, preload the count, program the alarm, and mask, clear and observe the alarm interrupt.

A build-time option, `GRAY_STORE`, sets the format in which the count and alarm values cross the register port. When the option is on, the values are in reflected Gray code: software writes `b ^ (b >> 1)` for a binary value `b` and converts reads back to binary. Inside the block the count is always held and incremented in plain binary. Conversion happens only at the register port.

Top module: `rtcsec_top`

## Requirements
- R1: A synchronous active-high reset clears the count, the alarm value, the control bits, the status bit, `alarm_irq` and `reg_rvalid`, and sets the mask bit to 1.
- R2: The word map is: control at 0, count load at 1, alarm at 2, mask at 8, clear at 9, status at 12 and live time at 13. Control keeps only bit 0 (alarm enable), bit 8 (clock source select, stored only) and bit 12 (timer run); its other bits read 0. Mask is bit 0 of word 8. Words 1 and 9, and every unmapped word, read 0. A read returns the register state from before its clock edge, with `reg_rvalid` high, one cycle after the request.
- R3: While timer run is 1, each tick adds one to the count, and the count wraps from 0xFFFFFFFF to 0.
- R4: While timer run is 0, ticks are ignored and the live-time word keeps returning the held count.
- R5: A write to the count-load word replaces the count at the next clock edge. It wins over a tick in the same cycle, so that tick neither advances the count nor raises a match.
- R6: With `GRAY_STORE`=1, load and alarm writes are decoded from Gray code. Live-time and alarm reads return the Gray code `b ^ (b >> 1)` of the binary value held.
- R7: Status bit 0 is set on a tick that advances the count to the alarm value while alarm enable is 1. No match is raised while alarm enable is 0. Once set, the bit holds until it is cleared.
- R8: Writing the clear word with bit 0 = 1 clears the status bit. A clear written with bit 0 = 0 has no effect. If a clear and a new match fall in the same cycle, the status bit stays set.
- R9: `alarm_irq` is high exactly when the status bit is 1, alarm enable is 1 and the mask bit is 0. It changes on the same edge as the register that causes the change.
- R10: Writes to the status and live-time words change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| alarm_irq | output | 1 | Alarm interrupt, registered |

## Verification
The assertions assume three things about the inputs. Reset is held high from the first edge. `tick_1hz` and `reg_valid` are synchronous to `clk`. Address and data are meaningful only in a cycle where `reg_valid` is high. The bench respects this by changing every input on the falling edge, giving each access a single cycle, and keeping reset high for three edges at the start.

Random loads are drawn a few seconds below the current alarm value. This places alarm matches among random ticks, clears and mask changes, so that the case where a clear and a match coincide actually occurs.

// File: rtl/rtcsec_pkg.sv
package rtcsec_pkg;
  // word offsets of the register port
  localparam int WORD_CTRL   = 0;
  localparam int WORD_LOAD   = 1;
  localparam int WORD_ALARM  = 2;
  localparam int WORD_MASK   = 8;
  localparam int WORD_CLEAR  = 9;
  localparam int WORD_STATUS = 12;
  localparam int WORD_TIME   = 13;

  // control field positions
  localparam int CTRL_ALARM_BIT = 0;
  localparam int CTRL_SRC_BIT   = 8;
  localparam int CTRL_RUN_BIT   = 12;

  typedef struct packed {
    logic run;
    logic src;
    logic alarm_en;
  } ctrl_t;
endpackage

// File: rtl/rtcsec_codec.sv
module rtcsec_codec #(
  parameter int W      = 32,
  parameter bit GRAY   = 1'b1,
  parameter bit DECODE = 1'b0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (!GRAY) begin : g_plain
      assign dout = din;
    end else if (!DECODE) begin : g_enc
      assign dout = din ^ (din >> 1);
    end else begin : g_dec
      // each binary bit is the parity of the gray bits at and above it
      always_comb begin
        for (int i = 0; i < W; i++) begin
          dout[i] = ^(din >> i);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rtcsec_regs.sv
module rtcsec_regs
  import rtcsec_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        wr_bits,   // {bit12, bit8, bit0} of write data
  input  logic [DATA_W-1:0] wdata_bin,
  output ctrl_t             ctrl_q,
  output ctrl_t             ctrl_d,
  output logic              mask_q,
  output logic              mask_d,
  output logic [DATA_W-1:0] alarm_q,
  output logic              load_stb,
  output logic [DATA_W-1:0] load_val,
  output logic              clr_stb
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(WORD_CTRL);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(WORD_LOAD);
  localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(WORD_ALARM);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(WORD_MASK);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(WORD_CLEAR);

  logic wr_ctrl, wr_alarm, wr_mask;

  assign wr_ctrl  = wr_stb && (addr == A_CTRL);
  assign wr_alarm = wr_stb && (addr == A_ALARM);
  assign wr_mask  = wr_stb && (addr == A_MASK);
  assign load_stb = wr_stb && (addr == A_LOAD);
  assign clr_stb  = wr_stb && (addr == A_CLEAR) && wr_bits[0];
  assign load_val = wdata_bin;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.run      = wr_bits[2];
      ctrl_d.src      = wr_bits[1];
      ctrl_d.alarm_en = wr_bits[0];
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (wr_mask) mask_d = wr_bits[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      mask_q  <= 1'b1;
      alarm_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      mask_q <= mask_d;
      if (wr_alarm) alarm_q <= wdata_bin;
    end
  end

  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && addr == A_MASK) |=> (mask_q == $past(wr_bits[0])));

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && addr == A_CTRL) |=> (ctrl_q.run == $past(wr_bits[2])));
endmodule

// File: rtl/rtcsec_counter.sv
module rtcsec_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              load_stb,
  input  logic [DATA_W-1:0] load_val,
  input  logic              alarm_en,
  input  logic [DATA_W-1:0] alarm_val,
  input  logic              clr_stb,
  output logic [DATA_W-1:0] count_q,
  output logic              status_q,
  output logic              status_d
);
  logic [DATA_W-1:0] count_inc;
  logic              advance;
  logic              match;

  assign count_inc = count_q + DATA_W'(1);
  assign advance   = tick && run && !load_stb;
  assign match     = advance && alarm_en && (count_inc == alarm_val);
  // a fresh match outranks a clear in the same cycle
  assign status_d  = match || (status_q && !clr_stb);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      status_q <= 1'b0;
    end else begin
      if (load_stb)     count_q <= load_val;
      else if (advance) count_q <= count_inc;
      status_q <= status_d;
    end
  end

  // R5
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> (count_q == $past(load_val)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_stb) |=> (count_q == $past(count_q)));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !load_stb) |=> (count_q == $past(count_q) + DATA_W'(1)));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q && !clr_stb) |=> status_q);

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && !(tick && run)) |=> !status_q);
endmodule

// File: rtl/rtcsec_readport.sv
module rtcsec_readport
  import rtcsec_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] addr,
  input  ctrl_t             ctrl,
  input  logic              mask,
  input  logic              status,
  input  logic [DATA_W-1:0] time_reg,
  input  logic [DATA_W-1:0] alarm_reg,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(WORD_CTRL): begin
        rd_mux[CTRL_ALARM_BIT] = ctrl.alarm_en;
        rd_mux[CTRL_SRC_BIT]   = ctrl.src;
        rd_mux[CTRL_RUN_BIT]   = ctrl.run;
      end
      ADDR_W'(WORD_ALARM):  rd_mux = alarm_reg;
      ADDR_W'(WORD_MASK):   rd_mux[0] = mask;
      ADDR_W'(WORD_STATUS): rd_mux[0] = status;
      ADDR_W'(WORD_TIME):   rd_mux = time_reg;
      default:              rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_stb;
      if (rd_stb) rdata_q <= rd_mux;
    end
  end

  // R2
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rvalid_q);

  // R2
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> !rvalid_q);
endmodule

// File: rtl/rtcsec_top.sv
module rtcsec_top
  import rtcsec_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter bit GRAY_STORE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              alarm_irq
);
  logic              wr_stb, rd_stb;
  logic [DATA_W-1:0] wdata_bin;
  ctrl_t             ctrl_q, ctrl_d;
  logic              mask_q, mask_d;
  logic [DATA_W-1:0] alarm_q;
  logic              load_stb, clr_stb;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] count_q;
  logic              status_q, status_d;
  logic [DATA_W-1:0] time_reg, alarm_reg;
  logic              irq_q;

  assign wr_stb = reg_valid && reg_write;
  assign rd_stb = reg_valid && !reg_write;

  rtcsec_codec #(.W(DATA_W), .GRAY(GRAY_STORE), .DECODE(1'b1)) u_wdec (
    .din(reg_wdata), .dout(wdata_bin));

  rtcsec_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(reg_addr),
    .wr_bits({reg_wdata[CTRL_RUN_BIT], reg_wdata[CTRL_SRC_BIT], reg_wdata[CTRL_ALARM_BIT]}),
    .wdata_bin(wdata_bin), .ctrl_q(ctrl_q), .ctrl_d(ctrl_d),
    .mask_q(mask_q), .mask_d(mask_d), .alarm_q(alarm_q),
    .load_stb(load_stb), .load_val(load_val), .clr_stb(clr_stb));

  rtcsec_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_1hz), .run(ctrl_q.run),
    .load_stb(load_stb), .load_val(load_val),
    .alarm_en(ctrl_q.alarm_en), .alarm_val(alarm_q), .clr_stb(clr_stb),
    .count_q(count_q), .status_q(status_q), .status_d(status_d));

  rtcsec_codec #(.W(DATA_W), .GRAY(GRAY_STORE), .DECODE(1'b0)) u_tenc (
    .din(count_q), .dout(time_reg));

  rtcsec_codec #(.W(DATA_W), .GRAY(GRAY_STORE), .DECODE(1'b0)) u_aenc (
    .din(alarm_q), .dout(alarm_reg));

  rtcsec_readport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .addr(reg_addr),
    .ctrl(ctrl_q), .mask(mask_q), .status(status_q),
    .time_reg(time_reg), .alarm_reg(alarm_reg),
    .rdata_q(reg_rdata), .rvalid_q(reg_rvalid));

  // interrupt registered from next-state values so it lines up with the registers
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= status_d && ctrl_d.alarm_en && !mask_d;
  end
  assign alarm_irq = irq_q;

  // R9
  irq_status_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_irq |-> status_q);

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    mask_q |-> !alarm_irq);

  // R9
  irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.alarm_en |-> !alarm_irq);
endmodule

// File: tb/rtcsec_top_test.sv
module rtcsec_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1hz = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        alarm_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_count = '0, m_alarm = '0, m_ctrl = '0;
  logic        m_mask = 1'b1, m_status = 1'b0, m_irq = 1'b0;

  always #5 clk = ~clk;

  rtcsec_top uut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .alarm_irq(alarm_irq));

  function automatic logic [31:0] genc(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gdec(input logic [31:0] g);
    logic [31:0] b;
    for (int i = 0; i < 32; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'd0:  return m_ctrl;
      4'd2:  return genc(m_alarm);
      4'd8:  return {31'b0, m_mask};
      4'd12: return {31'b0, m_status};
      4'd13: return genc(m_count);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, update reference at the rising edge, compare after it
  task automatic step(input logic v, input logic w, input logic [3:0] a,
                      input logic [31:0] d, input logic t, input string tag);
    logic [31:0] exp_rd, n_ctrl, n_alarm, n_count;
    logic        rd, wr, load, adv, match, clr, n_mask, n_status;
    reg_valid = v; reg_write = w; reg_addr = a; reg_wdata = d; tick_1hz = t;
    rd = v && !w;
    wr = v && w;
    exp_rd  = model_read(a);
    n_ctrl  = (wr && a == 4'd0) ? (d & 32'h0000_1101) : m_ctrl;
    n_mask  = (wr && a == 4'd8) ? d[0] : m_mask;
    n_alarm = (wr && a == 4'd2) ? gdec(d) : m_alarm;
    load    = wr && a == 4'd1;
    adv     = t && m_ctrl[12] && !load;
    match   = adv && m_ctrl[0] && (m_count + 32'd1 == m_alarm);
    clr     = wr && a == 4'd9 && d[0];
    n_count = load ? gdec(d) : (adv ? m_count + 32'd1 : m_count);
    n_status = match || (m_status && !clr);
    @(posedge clk);
    m_ctrl = n_ctrl; m_mask = n_mask; m_alarm = n_alarm;
    m_count = n_count; m_status = n_status;
    m_irq = m_status && m_ctrl[0] && !m_mask;
    @(negedge clk);
    reg_valid = 1'b0; tick_1hz = 1'b0;
    if (rd) begin
      check({31'b0, reg_rvalid}, 32'd1, tag);
      check(reg_rdata, exp_rd, tag);
    end
    check({31'b0, alarm_irq}, {31'b0, m_irq}, "R9");
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic t, input string tag);
    step(1'b1, 1'b1, a, d, t, tag);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'h0, 1'b0, tag);
  endtask

  task automatic idle(input logic t, input string tag);
    step(1'b0, 1'b0, 4'd0, 32'h0, t, tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check({31'b0, reg_rvalid}, 32'd0, "R1");
    check({31'b0, alarm_irq}, 32'd0, "R1");
    rd(4'd0, "R1"); rd(4'd2, "R1"); rd(4'd8, "R1");
    rd(4'd12, "R1"); rd(4'd13, "R1");

    // R2 control keeps only its three bits; write-only and unmapped words read 0
    wr(4'd0, 32'hFFFF_FFFF, 1'b0, "R2");
    rd(4'd0, "R2");
    rd(4'd1, "R2"); rd(4'd9, "R2"); rd(4'd5, "R2"); rd(4'd15, "R2");
    wr(4'd0, 32'h0000_1000, 1'b0, "R2");

    // R5 load beats a coincident tick
    wr(4'd1, genc(32'd5000), 1'b1, "R5");
    rd(4'd13, "R5");
    check(reg_rdata, genc(32'd5000), "R5");

    // R3 count steps and wraps
    idle(1'b1, "R3");
    rd(4'd13, "R3");
    wr(4'd1, genc(32'hFFFF_FFFF), 1'b0, "R3");
    idle(1'b1, "R3");
    rd(4'd13, "R3");
    check(reg_rdata, 32'h0, "R3");

    // R4 stopped timer ignores ticks
    wr(4'd0, 32'h0, 1'b0, "R4");
    idle(1'b1, "R4"); idle(1'b1, "R4");
    rd(4'd13, "R4");
    check(reg_rdata, 32'h0, "R4");

    // R6 gray round trip of alarm value
    wr(4'd2, genc(32'h1234_5678), 1'b0, "R6");
    rd(4'd2, "R6");
    check(reg_rdata, genc(32'h1234_5678), "R6");

    // R7 match sets status, R9 interrupt follows mask
    wr(4'd2, genc(32'd100), 1'b0, "R7");
    wr(4'd1, genc(32'd99), 1'b0, "R7");
    wr(4'd0, 32'h0000_1001, 1'b0, "R7");
    wr(4'd8, 32'h0, 1'b0, "R9");
    idle(1'b1, "R7");
    rd(4'd12, "R7");
    check(reg_rdata, 32'd1, "R7");
    check({31'b0, alarm_irq}, 32'd1, "R9");
    wr(4'd8, 32'h1, 1'b0, "R9");
    check({31'b0, alarm_irq}, 32'd0, "R9");
    wr(4'd8, 32'h0, 1'b0, "R9");

    // R8 clear with bit0=0 does nothing, bit0=1 clears
    wr(4'd9, 32'hFFFF_FFFE, 1'b0, "R8");
    rd(4'd12, "R8");
    check(reg_rdata, 32'd1, "R8");
    wr(4'd9, 32'h1, 1'b0, "R8");
    rd(4'd12, "R8");
    check(reg_rdata, 32'd0, "R8");

    // R8 clear coincident with a match leaves status set
    wr(4'd1, genc(32'd99), 1'b0, "R8");
    wr(4'd9, 32'h1, 1'b1, "R8");
    rd(4'd12, "R8");
    check(reg_rdata, 32'd1, "R8");

    // R7 no match while alarm enable is 0
    wr(4'd9, 32'h1, 1'b0, "R7");
    wr(4'd0, 32'h0000_1000, 1'b0, "R7");
    wr(4'd1, genc(32'd99), 1'b0, "R7");
    idle(1'b1, "R7");
    rd(4'd12, "R7");
    check(reg_rdata, 32'd0, "R7");

    // R10 writes to status and live-time words are ignored
    wr(4'd12, 32'hFFFF_FFFF, 1'b0, "R10");
    wr(4'd13, 32'hDEAD_BEEF, 1'b0, "R10");
    rd(4'd12, "R10");
    check(reg_rdata, 32'd0, "R10");
    rd(4'd13, "R10");
    check(reg_rdata, genc(32'd100), "R10");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic t;
      op = $urandom_range(0, 11);
      t  = $urandom_range(0, 1);
      case (op)
        0: wr(4'd0, ($urandom_range(0, 3) != 0) ? ($urandom | 32'h1000) : $urandom, t, "R2");
        1: wr(4'd1, genc(m_alarm - 32'($urandom_range(1, 4))), t, "R5");
        2: wr(4'd2, genc($urandom), t, "R6");
        3: wr(4'd8, {31'b0, ($urandom_range(0, 3) == 0)}, t, "R9");
        4: wr(4'd9, $urandom, t, "R8");
        5: wr(($urandom_range(0, 1) != 0) ? 4'd12 : 4'd13, $urandom, t, "R10");
        6: rd(4'd12, "R7");
        7: rd(4'd13, "R3");
        8: rd(4'd2, "R6");
        9: rd(4'($urandom_range(0, 15)), "R2");
        default: idle(t, "R4");
      endcase
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule